// File: doc/BRIEF.md
# Copy-Path Texel Alpha Filter

This block sits in a fast texture-to-image copy path and decides which pixels of each incoming 64-bit texel word may be written to the destination image. For every accepted word it returns the word unchanged, one cycle later, together with a write mask. The mask has one bit per byte lane for 8-bit destinations and one bit per 16-bit pixel for 16-bit destinations.

The pass rule is chosen by the pixel size of the destination image, never by the format the texels were stored in. With the test switched off every pixel passes. With it on, a 16-bit pixel passes on its alpha bit (its least significant bit), an 8-bit pixel passes when its value is at least a threshold, and a 4-bit destination rejects everything. The 8-bit threshold is either a software-set alpha register or a pseudo-random byte from an internal maximal-length LFSR, which draws a fresh value for each of the eight byte lanes of a word.

Top module: `cpy_alpha_test`

## Requirements
- R1: With `cmp_en` low, `out_mask` is 8'hFF for size codes 0, 1 and 3, and 8'h0F for size code 2 (16-bit pixels).
- R2: With `cmp_en` high and size code 2, mask bit j (j = 0..3) equals bit 16*j of the word, and mask bits 7:4 are 0.
- R3: With `cmp_en` high and size code 1, mask bit i (i = 0..7) is 1 exactly when byte i (bits 8*i+7:8*i) is greater than or equal to that lane's threshold, compared unsigned.
- R4: With `dith_en` low, the threshold of every byte lane is `blend_alpha`.
- R5: With `dith_en` high, the threshold of byte lane i is the LFSR state stepped i times from its current value; one step maps s to {s[6:0], s[7]^s[5]^s[4]^s[3]}.
- R6: The LFSR loads 8'hA5 in reset, advances by eight steps on each cycle with `in_valid` high and holds otherwise, and never holds zero.
- R7: With `cmp_en` high and size code 0 or 3 (4-bit destination), `out_mask` is 8'h00.
- R8: `out_valid`, `out_word` and `out_mask` are registered: one cycle after a cycle with `in_valid` high, `out_valid` is 1 and `out_word` equals that input word; after a cycle with `in_valid` low, `out_valid` is 0. In reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Texel word present this cycle |
| in_word | input | 64 | Texel word |
| dst_size | input | 2 | Destination pixel size: 0 = 4-bit, 1 = 8-bit, 2 = 16-bit, 3 = treated as 4-bit |
| cmp_en | input | 1 | Alpha test enable |
| dith_en | input | 1 | Use random threshold for 8-bit pixels |
| blend_alpha | input | 8 | Register threshold for 8-bit pixels |
| out_valid | output | 1 | Result present |
| out_word | output | 64 | Registered copy of the texel word |
| out_mask | output | 8 | Per-lane write mask |

## Verification
Every result is due exactly one clock edge after the cycle in which its word was presented, so the driver records the expected word and mask in a queue at the moment it drives the input, and the monitor pops one entry on each cycle where `out_valid` is seen just after the edge. The random thresholds are predicted by a step function kept in the bench and advanced only when a word is driven, so idle gaps between words test that the LFSR holds. Any result that arrives with an empty queue, or expected results left over at the end, count as failures.

// File: rtl/cpy_atest_pkg.sv
package cpy_atest_pkg;

   typedef enum logic [1:0] {
      DST_4B  = 2'd0,
      DST_8B  = 2'd1,
      DST_16B = 2'd2,
      DST_RSV = 2'd3
   } dst_size_e;

   // One step of the 8-bit maximal-length sequence x^8+x^6+x^5+x^4+1
   function automatic logic [7:0] rnd_step(input logic [7:0] s);
      return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
   endfunction

endpackage

// File: rtl/cpy_atest_lfsr.sv
module cpy_atest_lfsr #(
   parameter int          RW    = 8,
   parameter int          STEPS = 8,
   parameter logic [RW-1:0] SEED = 8'hA5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                adv,
   output logic [STEPS*RW-1:0] thr_flat
);
   import cpy_atest_pkg::*;

   generate
      if (RW != 8) begin : g_bad_rw
         $error("cpy_atest_lfsr: only an 8-bit sequence is provided");
      end
      if (SEED == '0) begin : g_bad_seed
         $error("cpy_atest_lfsr: seed must be nonzero");
      end
   endgenerate

   logic [RW-1:0] state_q;
   logic [RW-1:0] chain [STEPS+1];

   assign chain[0] = state_q;

   for (genvar k = 0; k < STEPS; k++) begin : g_chain
      assign chain[k+1] = rnd_step(chain[k]);
      assign thr_flat[k*RW +: RW] = chain[k];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)   state_q <= SEED;
      else if (adv) state_q <= chain[STEPS];
   end

   // R6: the sequence never reaches the all-zero lock-up state
   a_r6_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      state_q != '0);

   // R6: state holds while no word is accepted
   a_r6_lfsr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(state_q));

endmodule

// File: rtl/cpy_atest_lanes.sv
module cpy_atest_lanes #(
   parameter int WORD_W = 64,
   parameter int PW     = 8,
   localparam int NB    = WORD_W / PW,
   localparam int NH    = WORD_W / (2*PW)
) (
   input  logic [WORD_W-1:0] word,
   input  logic [1:0]        dst,
   input  logic              cmp_en,
   input  logic              dith_en,
   input  logic [PW-1:0]     blend_alpha,
   input  logic [NB*PW-1:0]  rnd_flat,
   output logic [NB-1:0]     mask
);
   import cpy_atest_pkg::*;

   logic [NB-1:0] ge8;
   logic [NB-1:0] a16;

   for (genvar i = 0; i < NB; i++) begin : g_byte
      logic [PW-1:0] thr;
      assign thr    = dith_en ? rnd_flat[i*PW +: PW] : blend_alpha;
      assign ge8[i] = word[i*PW +: PW] >= thr;
   end

   for (genvar j = 0; j < NB; j++) begin : g_half
      if (j < NH) begin : g_live
         assign a16[j] = word[j*2*PW];
      end else begin : g_pad
         assign a16[j] = 1'b0;
      end
   end

   logic [NB-1:0] all16;
   assign all16 = {{(NB-NH){1'b0}}, {NH{1'b1}}};

   always_comb begin
      unique case (dst_size_e'(dst))
         DST_8B:  mask = cmp_en ? ge8 : '1;
         DST_16B: mask = cmp_en ? a16 : all16;
         default: mask = cmp_en ? '0  : '1;
      endcase
   end

endmodule

// File: rtl/cpy_alpha_test.sv
module cpy_alpha_test #(
   parameter int         WORD_W = 64,
   parameter int         PW     = 8,
   parameter logic [7:0] SEED   = 8'hA5,
   localparam int        NB     = WORD_W / PW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [WORD_W-1:0] in_word,
   input  logic [1:0]        dst_size,
   input  logic              cmp_en,
   input  logic              dith_en,
   input  logic [PW-1:0]     blend_alpha,
   output logic              out_valid,
   output logic [WORD_W-1:0] out_word,
   output logic [NB-1:0]     out_mask
);
   import cpy_atest_pkg::*;

   generate
      if (PW != 8) begin : g_bad_pw
         $error("cpy_alpha_test: byte lanes must be 8 bits");
      end
      if (WORD_W % (2*PW) != 0) begin : g_bad_w
         $error("cpy_alpha_test: word must hold whole 16-bit pixels");
      end
   endgenerate

   logic [NB*PW-1:0] rnd_flat;
   logic [NB-1:0]    mask_d;

   cpy_atest_lfsr #(.RW(PW), .STEPS(NB), .SEED(SEED)) i_rnd (
      .clk      (clk),
      .rst_n    (rst_n),
      .adv      (in_valid),
      .thr_flat (rnd_flat)
   );

   cpy_atest_lanes #(.WORD_W(WORD_W), .PW(PW)) i_lanes (
      .word        (in_word),
      .dst         (dst_size),
      .cmp_en      (cmp_en),
      .dith_en     (dith_en),
      .blend_alpha (blend_alpha),
      .rnd_flat    (rnd_flat),
      .mask        (mask_d)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_word  <= '0;
         out_mask  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_word <= in_word;
            out_mask <= mask_d;
         end
      end
   end

   // R8: result follows its input by one cycle
   a_r8_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   a_r8_valid_fall: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   a_r8_word_copy: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_word == $past(in_word));

   // R1: test off passes every byte lane for 8-bit destinations
   a_r1_pass_all: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !cmp_en && dst_size == DST_8B |=> out_mask == '1);

   // R2: upper lanes never set for 16-bit destinations
   a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && dst_size == DST_16B |=> out_mask[NB-1:NB/2] == '0);

   // R7: 4-bit destinations reject all pixels under the test
   a_r7_fail_4b: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && cmp_en && (dst_size == DST_4B || dst_size == DST_RSV)
      |=> out_mask == '0);

endmodule

// File: tb/test_cpy_alpha_test.sv
module test_cpy_alpha_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [63:0] in_word = '0;
   logic [1:0]  dst_size = 2'd0;
   logic        cmp_en = 1'b0;
   logic        dith_en = 1'b0;
   logic [7:0]  blend_alpha = '0;
   logic        out_valid;
   logic [63:0] out_word;
   logic [7:0]  out_mask;

   always #4 clk = ~clk;

   cpy_alpha_test i_cpy_alpha_test (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
      .dst_size(dst_size), .cmp_en(cmp_en), .dith_en(dith_en),
      .blend_alpha(blend_alpha), .out_valid(out_valid),
      .out_word(out_word), .out_mask(out_mask)
   );

   typedef struct {
      logic [63:0] w;
      logic [7:0]  m;
      string       tag;
   } exp_t;

   exp_t        sb[$];
   int          checks = 0;
   int          errors = 0;
   logic [7:0]  model_rnd = 8'hA5;
   bit          done = 1'b0;

   function automatic logic [7:0] nxt(input logic [7:0] s);
      return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
   endfunction

   task automatic send(input logic [63:0] w, input logic [1:0] sz,
                       input logic en, input logic di, input logic [7:0] ba,
                       input string tag);
      exp_t e;
      logic [7:0] m;
      logic [7:0] r;
      @(negedge clk);
      in_valid = 1'b1; in_word = w; dst_size = sz;
      cmp_en = en; dith_en = di; blend_alpha = ba;
      m = '0;
      r = model_rnd;
      if (!en) m = (sz == 2'd2) ? 8'h0F : 8'hFF;
      else if (sz == 2'd2) begin
         for (int j = 0; j < 4; j++) m[j] = w[16*j];
      end else if (sz == 2'd1) begin
         for (int i = 0; i < 8; i++) begin
            m[i] = w[8*i +: 8] >= (di ? r : ba);
            r = nxt(r);
         end
      end
      for (int k = 0; k < 8; k++) model_rnd = nxt(model_rnd);
      e.w = w; e.m = m; e.tag = tag;
      sb.push_back(e);
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         in_valid = 1'b0;
         in_word = 64'hDEAD_BEEF_0BAD_F00D;
      end
   endtask

   // monitor: sample just after each edge
   always begin
      @(posedge clk);
      #1;
      if (rst_n && !done && out_valid) begin
         checks++;
         if (sb.size() == 0) begin
            errors++;
            $display("FAIL R8 unexpected result word=%h mask=%h expected none",
                     out_word, out_mask);
         end else begin
            exp_t e;
            e = sb.pop_front();
            if (out_word !== e.w || out_mask !== e.m) begin
               errors++;
               $display("FAIL %s word=%h mask=%h expected word=%h mask=%h",
                        e.tag, out_word, out_mask, e.w, e.m);
            end
         end
      end
   end

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R8: reset state
      checks++;
      if (out_valid !== 1'b0 || out_mask !== 8'h00 || out_word !== 64'h0) begin
         errors++;
         $display("FAIL R8 reset v=%b mask=%h word=%h expected 0/00/0",
                  out_valid, out_mask, out_word);
      end
      rst_n = 1'b1;

      // R1: test disabled
      send(64'h0000_0000_0000_0000, 2'd1, 1'b0, 1'b0, 8'hFF, "R1 off 8b");
      send(64'h0000_0000_0000_0000, 2'd2, 1'b0, 1'b0, 8'hFF, "R1 off 16b");
      send(64'h1234_5678_9ABC_DEF0, 2'd0, 1'b0, 1'b0, 8'h00, "R1 off 4b");
      // R2: alpha bit per 16-bit pixel
      send(64'h0001_FFFE_0000_7FFF, 2'd2, 1'b1, 1'b0, 8'h00, "R2 16b a");
      send(64'hFFFF_0001_FFFE_0001, 2'd2, 1'b1, 1'b1, 8'h00, "R2 16b b");
      // R3/R4: register threshold, boundaries around 0x80
      send(64'h7F80_8100_FF01_807E, 2'd1, 1'b1, 1'b0, 8'h80, "R3 R4 thr80");
      send(64'h0000_0000_0000_0000, 2'd1, 1'b1, 1'b0, 8'h00, "R4 thr00");
      send(64'hFFFE_FDFF_0102_FF00, 2'd1, 1'b1, 1'b0, 8'hFF, "R4 thrFF");
      idle(2);
      // R5/R6: random thresholds, with idle gaps in between
      send(64'h0011_2233_4455_6677, 2'd1, 1'b1, 1'b1, 8'h00, "R5 rnd a");
      send(64'h8899_AABB_CCDD_EEFF, 2'd1, 1'b1, 1'b1, 8'hFF, "R5 rnd b");
      idle(3);
      send(64'h7F7F_7F7F_8080_8080, 2'd1, 1'b1, 1'b1, 8'h00, "R6 rnd hold");
      send(64'hA5A5_A5A5_5A5A_5A5A, 2'd2, 1'b1, 1'b1, 8'h00, "R6 adv 16b");
      send(64'h3C3C_C3C3_6996_9669, 2'd1, 1'b1, 1'b1, 8'h00, "R6 rnd after");
      // R7: 4-bit destination with test on
      send(64'hFFFF_FFFF_FFFF_FFFF, 2'd0, 1'b1, 1'b0, 8'h00, "R7 4b");
      send(64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 1'b1, 1'b1, 8'h00, "R7 code3");
      // R8: back-to-back stream, word passthrough
      for (int k = 0; k < 6; k++)
         send({8{8'(k * 37 + 11)}}, 2'(k % 3), 1'b1, k[0], 8'(k * 40),
              "R8 stream");
      idle(4);
      // R8: idle output after gaps, queue drained
      checks++;
      if (out_valid !== 1'b0 || sb.size() != 0) begin
         errors++;
         $display("FAIL R8 drain v=%b left=%0d expected 0/0",
                  out_valid, sb.size());
      end
      finish_run();
   end

endmodule